// File: doc/BRIEF.md
# Memory Controller Event Counter Unit

This block counts activity inside a memory controller. It has a bank of programmable counters. Each counter watches one line of a vector of single-cycle event pulses, and an 8-bit event code that software writes chooses the line. Counting is gated twice: a unit-wide run bit and a per-counter enable bit. This lets software freeze all counters at the same moment and read a consistent set of values.

When a counter rolls over, it raises a sticky pending bit. Software can mask each pending bit and clears it by writing a one. A single level interrupt output is high while any unmasked pending bit is set. All state is reached through a plain synchronous register port: a request with a write flag, a 12-bit byte offset and 64-bit data. Read data is registered.

Top module: `mc_evt_counter_unit`

## Requirements
- R1: After reset all counters, event codes, counter enables, the run bit (offset 0xEA0) and pending bits (offset 0x52C) read 0, every mask bit (offset 0x528) reads 1, and `irq_o` is 0.
- R2: Counter n is one 64-bit register at offset 0xE00 + 8*n. A write loads the low 48 data bits. A read returns the 48-bit value zero-extended. Read data appears on `bus_rdata_o` in the cycle after the request.
- R3: The event code of counter n lives in bits [7:0] at offset 0xE74 + 4*n, and higher written bits read back 0. Code 0x00 counts every clock. Code c in 0x01..0x90 counts pulses on `evt_i[c-1]`, so 0x83 counts `evt_i[130]` (write data flux) and 0x84 counts `evt_i[131]` (read data flux). Codes above 0x90 never count.
- R4: A counter adds exactly one in a cycle only when run bit 0 at 0xEA0, its enable bit n at 0xE70 and its selected event are all 1. Clearing the run bit or the enable bit holds the counter value.
- R5: When counter n rolls over from all ones to zero, pending bit n at 0x52C becomes 1.
- R6: Writing to offset 0x530 clears each pending bit whose data bit is 1. Zero data bits leave pending bits unchanged. Writes to 0x52C are ignored.
- R7: Mask bit n at 0x528 set to 1 blocks pending bit n from the interrupt. `irq_o` is the OR of the pending bits whose mask bit is 0.
- R8: A register write to a counter in a cycle where it would also increment loads the written value, and no rollover is flagged for that cycle.
- R9: Offset 0x710 reads the constant identifier `VERSION_ID` (default 0x00000200) and ignores writes. Reads of any offset with no register, including 0x530, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 144 | Event pulse lines for codes 0x01..0x90 |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte offset of the register |
| bus_wdata_i | input | 64 | Write data |
| bus_rdata_o | output | 64 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Level interrupt from unmasked pending bits |

## Verification
The bench builds the unit with its default parameters: eight 48-bit counters, 8-bit codes and 144 event lines. It therefore covers the real offset layout and the highest mapped code, 0x90. A 48-bit rollover is reached in a few cycles because counters are writable: the bench preloads values just below all ones and then drives events or cycle counting. The same preload puts a software write and an increment from all ones into one cycle, which exposes the write-priority and no-rollover rule.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  localparam int unsigned CNT_BASE    = 'hE00;
  localparam int unsigned CNT_STRIDE  = 8;
  localparam int unsigned CODE_BASE   = 'hE74;
  localparam int unsigned CODE_STRIDE = 4;
  localparam int unsigned ENA_OFF     = 'hE70;
  localparam int unsigned RUN_OFF     = 'hEA0;
  localparam int unsigned MASK_OFF    = 'h528;
  localparam int unsigned PEND_OFF    = 'h52C;
  localparam int unsigned CLR_OFF     = 'h530;
  localparam int unsigned VER_OFF     = 'h710;
endpackage

// File: rtl/evt_cnt_slice.sv
module evt_cnt_slice #(
  parameter int unsigned CTR_W  = 48,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned EVT_W  = 144
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              ena_i,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              code_we_i,
  input  logic              cnt_we_i,
  input  logic [CODE_W-1:0] code_wdata_i,
  input  logic [CTR_W-1:0]  cnt_wdata_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CTR_W-1:0]  cnt_o,
  output logic              wrap_o
);
  logic [CODE_W-1:0] code_q;
  logic [CTR_W-1:0]  cnt_q;
  logic              sel;
  logic              inc;

  // code 0 = clock cycles, code c = evt_i[c-1]
  always_comb begin
    sel = (code_q == '0);
    for (int c = 1; c <= int'(EVT_W); c++) begin
      if (code_q == CODE_W'(c)) sel = evt_i[c-1];
    end
  end

  assign inc    = run_i & ena_i & sel;
  assign wrap_o = inc & ~cnt_we_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (code_we_i) code_q <= code_wdata_i;
      if (cnt_we_i)  cnt_q  <= cnt_wdata_i;
      else if (inc)  cnt_q  <= cnt_q + CTR_W'(1);
    end
  end

  assign code_o = code_q;
  assign cnt_o  = cnt_q;

  // R4
  hold_when_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_we_i) |=> $stable(cnt_q));
  // R4
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_we_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CTR_W'(1)));
  // R8
  sw_write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> (cnt_q == $past(cnt_wdata_i)));
  // R3
  unmapped_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q > CODE_W'(EVT_W) && !cnt_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] wrap_i,
  input  logic         mask_we_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  logic [N-1:0] mask_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] clr_bits;

  assign clr_bits = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      if (mask_we_i) mask_q <= wdata_i;
      pend_q <= (pend_q & ~clr_bits) | wrap_i;
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & ~mask_q);

  // R5
  wrap_sets_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wrap_i) |=> ((pend_q & $past(wrap_i)) == $past(wrap_i)));
  // R6
  pend_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  // R7
  all_masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> !irq_o);
endmodule

// File: rtl/mc_evt_counter_unit.sv
module mc_evt_counter_unit
  import evt_cnt_pkg::*;
#(
  parameter int unsigned NUM_CTR    = 8,
  parameter int unsigned CTR_W      = 48,
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned EVT_W      = 144,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 64,
  parameter logic [31:0] VERSION_ID = 32'h0000_0200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic wr, rd;
  logic run_we, ena_we, mask_we, clr_we;
  logic run_q;
  logic [NUM_CTR-1:0] ena_q;
  logic [NUM_CTR-1:0] cnt_we, code_we, wrap;
  logic [NUM_CTR-1:0] mask, pend;
  logic [CTR_W-1:0]   cnt  [NUM_CTR];
  logic [CODE_W-1:0]  code [NUM_CTR];
  logic [DATA_W-1:0]  rd_d, rdata_q;
  logic               unused_wdata;

  assign wr = bus_req_i & bus_we_i;
  assign rd = bus_req_i & ~bus_we_i;

  assign run_we  = wr && bus_addr_i == ADDR_W'(RUN_OFF);
  assign ena_we  = wr && bus_addr_i == ADDR_W'(ENA_OFF);
  assign mask_we = wr && bus_addr_i == ADDR_W'(MASK_OFF);
  assign clr_we  = wr && bus_addr_i == ADDR_W'(CLR_OFF);
  assign unused_wdata = ^bus_wdata_i[DATA_W-1:CTR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      ena_q <= '0;
    end else begin
      if (run_we) run_q <= bus_wdata_i[0];
      if (ena_we) ena_q <= bus_wdata_i[NUM_CTR-1:0];
    end
  end

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    assign cnt_we[n]  = wr && bus_addr_i == ADDR_W'(CNT_BASE + CNT_STRIDE * n);
    assign code_we[n] = wr && bus_addr_i == ADDR_W'(CODE_BASE + CODE_STRIDE * n);

    evt_cnt_slice #(
      .CTR_W (CTR_W),
      .CODE_W(CODE_W),
      .EVT_W (EVT_W)
    ) u_slice (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (run_q),
      .ena_i       (ena_q[n]),
      .evt_i       (evt_i),
      .code_we_i   (code_we[n]),
      .cnt_we_i    (cnt_we[n]),
      .code_wdata_i(bus_wdata_i[CODE_W-1:0]),
      .cnt_wdata_i (bus_wdata_i[CTR_W-1:0]),
      .code_o      (code[n]),
      .cnt_o       (cnt[n]),
      .wrap_o      (wrap[n])
    );
  end

  evt_irq_ctrl #(.N(NUM_CTR)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wrap_i   (wrap),
    .mask_we_i(mask_we),
    .clr_we_i (clr_we),
    .wdata_i  (bus_wdata_i[NUM_CTR-1:0]),
    .mask_o   (mask),
    .pend_o   (pend),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_d = '0;
    if (bus_addr_i == ADDR_W'(RUN_OFF))  rd_d = DATA_W'(run_q);
    if (bus_addr_i == ADDR_W'(ENA_OFF))  rd_d = DATA_W'(ena_q);
    if (bus_addr_i == ADDR_W'(MASK_OFF)) rd_d = DATA_W'(mask);
    if (bus_addr_i == ADDR_W'(PEND_OFF)) rd_d = DATA_W'(pend);
    if (bus_addr_i == ADDR_W'(VER_OFF))  rd_d = DATA_W'(VERSION_ID);
    for (int n = 0; n < int'(NUM_CTR); n++) begin
      if (bus_addr_i == ADDR_W'(CNT_BASE + CNT_STRIDE * n))   rd_d = DATA_W'(cnt[n]);
      if (bus_addr_i == ADDR_W'(CODE_BASE + CODE_STRIDE * n)) rd_d = DATA_W'(code[n]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd ? rd_d : '0;
  end

  assign bus_rdata_o = rdata_q;

  // R9
  version_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && bus_addr_i == ADDR_W'(VER_OFF)) |=> (bus_rdata_o == DATA_W'(VERSION_ID)));
  // R7
  irq_needs_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend != '0));
  // R9
  clr_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && bus_addr_i == ADDR_W'(CLR_OFF)) |=> (bus_rdata_o == '0));
endmodule

// File: tb/sim_mc_evt_counter_unit.sv
`timescale 1ns/1ps
module sim_mc_evt_counter_unit;
  localparam logic [47:0] MAXC = 48'hFFFF_FFFF_FFFF;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [143:0] evt = '0;
  logic         req = 1'b0, we = 1'b0;
  logic [11:0]  addr = '0;
  logic [63:0]  wdata = '0;
  logic [63:0]  rdata;
  logic         irq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mc_evt_counter_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req_tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req_tag, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    req = 1'b0;
  endtask

  task automatic pulse(input logic [143:0] pat, input int n);
    evt = pat;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    chk("R1 irq", 64'(irq), 64'h0);
    rd(12'hE00, v); chk("R1 cnt0", v, 64'h0);
    rd(12'hE38, v); chk("R1 cnt7", v, 64'h0);
    rd(12'hE90, v); chk("R1 code7", v, 64'h0);
    rd(12'hE70, v); chk("R1 ena", v, 64'h0);
    rd(12'hEA0, v); chk("R1 run", v, 64'h0);
    rd(12'h528, v); chk("R1 mask", v, 64'hFF);
    rd(12'h52C, v); chk("R1 pend", v, 64'h0);
  endtask

  task automatic t_rw;
    logic [63:0] v;
    wr(12'hE18, 64'hFFFF_1234_5678_9ABC);
    rd(12'hE18, v); chk("R2 cnt3 rw", v, 64'h0000_1234_5678_9ABC);
    wr(12'hE7C, 64'h1FF);
    rd(12'hE7C, v); chk("R3 code width", v, 64'hFF);
  endtask

  task automatic t_version;
    logic [63:0] v;
    rd(12'h710, v); chk("R9 version", v, 64'h200);
    wr(12'h710, 64'hDEAD);
    rd(12'h710, v); chk("R9 version ro", v, 64'h200);
    rd(12'h0F0, v); chk("R9 unmapped", v, 64'h0);
    rd(12'h530, v); chk("R9 clr reads 0", v, 64'h0);
  endtask

  task automatic t_events;
    logic [63:0] v;
    wr(12'hE18, 64'h0);
    wr(12'hE74, 64'h83);
    wr(12'hE78, 64'h84);
    wr(12'hE7C, 64'h90);
    wr(12'hE80, 64'hA0);
    wr(12'hE70, 64'h0F);
    wr(12'hEA0, 64'h1);
    pulse(144'(1) << 130, 5);
    pulse(144'(1) << 131, 3);
    pulse(144'(1) << 143, 2);
    pulse('1, 4);
    rd(12'hE00, v); chk("R3 code 0x83", v, 64'd9);
    rd(12'hE08, v); chk("R3 code 0x84", v, 64'd7);
    rd(12'hE10, v); chk("R3 code 0x90", v, 64'd6);
    rd(12'hE18, v); chk("R3 unmapped code", v, 64'd0);
    wr(12'hEA0, 64'h0);
    pulse('1, 3);
    rd(12'hE00, v); chk("R4 run off holds", v, 64'd9);
    wr(12'hEA0, 64'h1);
    wr(12'hE70, 64'h01);
    pulse('1, 2);
    wr(12'hEA0, 64'h0);
    rd(12'hE00, v); chk("R4 enabled counts", v, 64'd11);
    rd(12'hE08, v); chk("R4 disabled holds", v, 64'd7);
  endtask

  task automatic t_cycles;
    logic [63:0] v;
    wr(12'hE84, 64'h00);
    wr(12'hE70, 64'h10);
    wr(12'hEA0, 64'h1);
    repeat (9) @(negedge clk);
    wr(12'hEA0, 64'h0);
    rd(12'hE20, v); chk("R3 cycle code", v, 64'd10);
  endtask

  task automatic t_wrap;
    logic [63:0] v;
    wr(12'hE70, 64'h20);
    wr(12'hE88, 64'h83);
    wr(12'hE28, 64'(MAXC - 48'd1));
    wr(12'hEA0, 64'h1);
    pulse(144'(1) << 130, 2);
    wr(12'hEA0, 64'h0);
    rd(12'hE28, v); chk("R5 wrap value", v, 64'h0);
    rd(12'h52C, v); chk("R5 pend set", v, 64'h20);
    chk("R7 masked irq", 64'(irq), 64'h0);
    wr(12'h528, 64'hDF);
    chk("R7 unmasked irq", 64'(irq), 64'h1);
    wr(12'h530, 64'h0);
    rd(12'h52C, v); chk("R6 zero clr", v, 64'h20);
    wr(12'h52C, 64'h0);
    rd(12'h52C, v); chk("R6 pend ro", v, 64'h20);
    wr(12'h530, 64'h20);
    rd(12'h52C, v); chk("R6 w1c", v, 64'h0);
    chk("R7 irq drops", 64'(irq), 64'h0);
  endtask

  task automatic t_sw_wins;
    logic [63:0] v;
    wr(12'hE70, 64'h40);
    wr(12'hE8C, 64'h00);
    wr(12'hE30, 64'(MAXC));
    wr(12'hEA0, 64'h1);
    wr(12'hE30, 64'd7);
    wr(12'hEA0, 64'h0);
    rd(12'hE30, v); chk("R8 write wins", v, 64'd8);
    rd(12'h52C, v); chk("R8 no wrap flag", v, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset;
    t_rw;
    t_version;
    t_events;
    t_cycles;
    t_wrap;
    t_sw_wins;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule